// File: doc/BRIEF.md
# DRAM Clock-Enable Power Controller

This block drives the per-rank clock-enable lines and the output enables of the clock-enable and chip-select pads of a four-rank DDR3 memory interface. During power-up and reset every clock-enable is held low. Clock-enable stays low until software writes a configuration word with its release bit set, so how long the memory is kept inactive is up to software and does not depend on a counter in hardware.

Every rank counts as populated after reset, so its pads are driven. When software clears a rank's presence bit and also sets the float-enable bit, that rank's clock-enable and chip-select pads stop being driven. A small state machine puts the memory into self-refresh and brings it back out, following a package power-state code. In the shallow and deep idle states, self-refresh is entered only when no memory request is pending. For suspend-to-RAM, the block first asks the controller to flush outstanding cycles and waits for that flush to be acknowledged. Single-cycle entry and exit pulses tell the command scheduler when the memory changes state.

Top module: `dram_cke_pwr_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `cke` is 0000, `cke_oe` and `cs_oe` are 1111, and `flush_req`, `sr_enter` and `sr_exit` are 0. This is also the state after a reset taken from self-refresh.
- R2: `cke` stays 0000 after reset until a clock edge on which `cfg_wr` and `cfg_cke_release` are both 1. A write with `cfg_cke_release` = 0 leaves `cke` at 0000.
- R3: Each `cfg_wr` stores `cfg_rank_present` (bit r = rank r) and `cfg_float_en`, which take effect from the next cycle. Their reset values are 1111 and 0. Once released and out of self-refresh, `cke` equals the stored presence mask.
- R4: For each rank r, `cke_oe[r]` and `cs_oe[r]` are 0 exactly when the stored float enable is 1 and presence bit r is 0. Otherwise they are 1.
- R5: The power code `pwr_state` is 0 for C0, 1 for C3, 2 for C6 and 3 for suspend-to-RAM. When the block is running and the code is 1 or 2 with `req_pending` = 0, `sr_enter` is 1 in that cycle while `cke` is still high, and `cke` is 0000 from the next cycle. While `req_pending` = 1, no entry happens.
- R6: When the block is running and the code is 3, `flush_req` is 1 from the next cycle while `cke` stays high. In the cycle where `flush_done` = 1, `sr_enter` is 1, and from the next cycle `cke` is 0000 and `flush_req` is 0. If the code leaves 3 before the flush is acknowledged, the block goes back to running without entering self-refresh.
- R7: In self-refresh, `cke` is 0000 in every cycle.
- R8: Self-refresh is left on the edge where the code is 0, or where the code is 1 or 2 with `req_pending` = 1. In the next cycle `sr_exit` is 1 for one cycle and `cke` equals the presence mask. Under code 3, `req_pending` does not cause an exit.
- R9: `sr_enter` and `sr_exit` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cke_release | input | 1 | Release clock-enable from its power-up hold |
| cfg_rank_present | input | 4 | Presence bit per rank |
| cfg_float_en | input | 1 | Allow pads of absent ranks to float |
| pwr_state | input | 2 | Package power-state code |
| req_pending | input | 1 | Memory requests are outstanding |
| flush_done | input | 1 | Flush of pending cycles is complete |
| cke | output | 4 | Clock-enable per rank |
| cke_oe | output | 4 | Output enable of each clock-enable pad |
| cs_oe | output | 4 | Output enable of each chip-select pad |
| flush_req | output | 1 | Request to flush pending cycles |
| sr_enter | output | 1 | One-cycle pulse: self-refresh entry |
| sr_exit | output | 1 | One-cycle pulse: self-refresh exit |

## Verification
The assertions assume that `flush_done` is only meaningful while a flush is requested and that every input is stable from just after one falling edge to the next. The bench changes its inputs only just after falling edges, and it raises `flush_done` only while `flush_req` is high. It sweeps all sixteen presence masks with both float settings. It walks every power code through entry, hold and exit, including an aborted flush and a reset taken from self-refresh.

// File: rtl/dcke_pkg.sv
package dcke_pkg;

    localparam int DEF_RANKS = 4;

    typedef enum logic [2:0] {
        RESET_HOLD,
        ACTIVE,
        FLUSH,
        SELF_REFRESH,
        EXIT
    } cke_state_e;

    typedef enum logic [1:0] {
        PS_C0  = 2'd0,
        PS_C3  = 2'd1,
        PS_C6  = 2'd2,
        PS_STR = 2'd3
    } pkg_pstate_e;

    typedef struct packed {
        logic cke_on;
        logic flush_req;
        logic sr_enter;
        logic sr_exit;
    } fsm_out_t;

    function automatic logic idle_state(input pkg_pstate_e ps);
        return (ps == PS_C3) || (ps == PS_C6);
    endfunction

    function automatic logic wake_cond(input pkg_pstate_e ps, input logic req);
        return (ps == PS_C0) || (idle_state(ps) && req);
    endfunction

endpackage

// File: rtl/cke_cfg_regs.sv
module cke_cfg_regs #(
    parameter int NR = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [NR-1:0] present_in,
    input  logic          float_in,
    output logic [NR-1:0] present_q,
    output logic          float_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '1;
            float_q   <= 1'b0;
        end else if (wr) begin
            present_q <= present_in;
            float_q   <= float_in;
        end
    end
endmodule

// File: rtl/cke_sr_fsm.sv
module cke_sr_fsm
    import dcke_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rel_wr,
    input  pkg_pstate_e pstate,
    input  logic        req_pending,
    input  logic        flush_done,
    output fsm_out_t    o,
    output cke_state_e  state_o
);
    cke_state_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= RESET_HOLD;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        o   = '0;
        case (st)
            RESET_HOLD: begin
                if (rel_wr) nxt = ACTIVE;
            end
            ACTIVE: begin
                o.cke_on = 1'b1;
                if (pstate == PS_STR) begin
                    nxt = FLUSH;
                end else if (idle_state(pstate) && !req_pending) begin
                    nxt = SELF_REFRESH;
                    o.sr_enter = 1'b1;
                end
            end
            FLUSH: begin
                o.cke_on    = 1'b1;
                o.flush_req = 1'b1;
                if (pstate != PS_STR) begin
                    nxt = ACTIVE;
                end else if (flush_done) begin
                    nxt = SELF_REFRESH;
                    o.sr_enter = 1'b1;
                end
            end
            SELF_REFRESH: begin
                if (wake_cond(pstate, req_pending)) nxt = EXIT;
            end
            EXIT: begin
                o.cke_on  = 1'b1;
                o.sr_exit = 1'b1;
                nxt       = ACTIVE;
            end
            default: nxt = RESET_HOLD;
        endcase
    end

    assign state_o = st;

    // R5 and R6: entry only with no pending requests, or after the flush is acknowledged
    assert_entry_guard_R5: assert property (@(posedge clk) disable iff (rst)
        o.sr_enter |-> ((pstate == PS_STR) ? flush_done : !req_pending));

    assert_entry_lands_R6: assert property (@(posedge clk) disable iff (rst)
        o.sr_enter |=> (st == SELF_REFRESH));

    assert_exit_returns_R8: assert property (@(posedge clk) disable iff (rst)
        o.sr_exit |=> (st == ACTIVE));

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o.sr_enter, o.sr_exit}));
endmodule

// File: rtl/cke_rank_drv.sv
module cke_rank_drv #(
    parameter int NR = 4
) (
    input  logic          cke_on,
    input  logic [NR-1:0] present,
    input  logic          float_en,
    output logic [NR-1:0] cke,
    output logic [NR-1:0] cke_oe,
    output logic [NR-1:0] cs_oe
);
    for (genvar r = 0; r < NR; r++) begin : g_rank
        logic drive;
        assign drive     = present[r] | ~float_en;
        assign cke[r]    = cke_on & present[r];
        assign cke_oe[r] = drive;
        assign cs_oe[r]  = drive;
    end
endmodule

// File: rtl/dram_cke_pwr_ctrl.sv
module dram_cke_pwr_ctrl
    import dcke_pkg::*;
#(
    parameter int NUM_RANKS = DEF_RANKS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic                 cfg_cke_release,
    input  logic [NUM_RANKS-1:0] cfg_rank_present,
    input  logic                 cfg_float_en,
    input  logic [1:0]           pwr_state,
    input  logic                 req_pending,
    input  logic                 flush_done,
    output logic [NUM_RANKS-1:0] cke,
    output logic [NUM_RANKS-1:0] cke_oe,
    output logic [NUM_RANKS-1:0] cs_oe,
    output logic                 flush_req,
    output logic                 sr_enter,
    output logic                 sr_exit
);
    logic [NUM_RANKS-1:0] present_q;
    logic                 float_q;
    fsm_out_t             fo;
    cke_state_e           st;

    cke_cfg_regs #(.NR(NUM_RANKS)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .present_in (cfg_rank_present),
        .float_in   (cfg_float_en),
        .present_q  (present_q),
        .float_q    (float_q)
    );

    cke_sr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rel_wr      (cfg_wr & cfg_cke_release),
        .pstate      (pkg_pstate_e'(pwr_state)),
        .req_pending (req_pending),
        .flush_done  (flush_done),
        .o           (fo),
        .state_o     (st)
    );

    cke_rank_drv #(.NR(NUM_RANKS)) u_drv (
        .cke_on   (fo.cke_on),
        .present  (present_q),
        .float_en (float_q),
        .cke      (cke),
        .cke_oe   (cke_oe),
        .cs_oe    (cs_oe)
    );

    assign flush_req = fo.flush_req;
    assign sr_enter  = fo.sr_enter;
    assign sr_exit   = fo.sr_exit;

    // R2: clock-enable stays low during the power-up hold
    assert_hold_low_R2: assert property (@(posedge clk) disable iff (rst)
        (st == RESET_HOLD) |-> (cke == '0));

    // R3: absent ranks never see clock-enable high
    assert_absent_low_R3: assert property (@(posedge clk) disable iff (rst)
        ((cke & ~present_q) == '0));

    // R4: without float enable every pad is driven
    assert_all_driven_R4: assert property (@(posedge clk) disable iff (rst)
        !float_q |-> (&cke_oe && &cs_oe));

    // R7: clock-enable falls right after the entry pulse
    assert_low_after_enter_R7: assert property (@(posedge clk) disable iff (rst)
        sr_enter |=> (cke == '0));

    // R8: exit pulse coincides with clock-enable on populated ranks
    assert_exit_raises_R8: assert property (@(posedge clk) disable iff (rst)
        sr_exit |-> (cke == present_q));
endmodule

// File: tb/dram_cke_pwr_ctrl_tb_top.sv
module dram_cke_pwr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr, cfg_cke_release, cfg_float_en;
    logic [3:0] cfg_rank_present;
    logic [1:0] pwr_state;
    logic       req_pending, flush_done;
    logic [3:0] cke, cke_oe, cs_oe;
    logic       flush_req, sr_enter, sr_exit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dram_cke_pwr_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cke_release(cfg_cke_release),
        .cfg_rank_present(cfg_rank_present), .cfg_float_en(cfg_float_en),
        .pwr_state(pwr_state), .req_pending(req_pending), .flush_done(flush_done),
        .cke(cke), .cke_oe(cke_oe), .cs_oe(cs_oe), .flush_req(flush_req),
        .sr_enter(sr_enter), .sr_exit(sr_exit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg(input logic rel, input logic [3:0] m, input logic fl);
        cfg_wr = 1'b1; cfg_cke_release = rel; cfg_rank_present = m; cfg_float_en = fl;
        step();
        cfg_wr = 1'b0; cfg_cke_release = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    localparam logic [3:0] M = 4'b1011;

    initial begin
        rst = 1'b1; cfg_wr = 0; cfg_cke_release = 0; cfg_rank_present = 4'hF;
        cfg_float_en = 0; pwr_state = 2'd0; req_pending = 0; flush_done = 0;
        step(); step(); step();
        chk("R1 cke in reset", 32'(cke), 0);
        rst = 1'b0;
        step();
        chk("R1 cke", 32'(cke), 0);
        chk("R1 cke_oe", 32'(cke_oe), 4'hF);
        chk("R1 cs_oe", 32'(cs_oe), 4'hF);
        chk("R1 flush_req", 32'(flush_req), 0);
        chk("R1 sr_enter", 32'(sr_enter), 0);
        chk("R1 sr_exit", 32'(sr_exit), 0);

        repeat (4) step();
        chk("R2 hold low", 32'(cke), 0);
        cfg(1'b0, 4'hF, 1'b0);
        step();
        chk("R2 write without release", 32'(cke), 0);

        // R3 / R4 sweep over every presence mask and float setting
        for (int m = 0; m < 16; m++) begin
            for (int t = 0; t < 2; t++) begin
                cfg(1'b1, 4'(m), 1'(t));
                chk("R3 cke follows mask", 32'(cke), 32'(m));
                chk("R4 cke_oe", 32'(cke_oe), (t == 1) ? 32'(m) : 32'hF);
                chk("R4 cs_oe", 32'(cs_oe), (t == 1) ? 32'(m) : 32'hF);
            end
        end
        cfg(1'b0, M, 1'b1);
        chk("R3 mask kept", 32'(cke), 32'(M));

        // R5: C3 with requests pending holds off entry
        pwr_state = 2'd1; req_pending = 1; #1;
        chk("R5 no entry while pending", 32'(sr_enter), 0);
        repeat (3) step();
        chk("R5 still active", 32'(cke), 32'(M));
        req_pending = 0; #1;
        chk("R5 enter pulse", 32'(sr_enter), 1);
        chk("R5 cke high at pulse", 32'(cke), 32'(M));
        step();
        chk("R5 cke low after entry", 32'(cke), 0);
        chk("R5 pulse one cycle", 32'(sr_enter), 0);
        step(); step();
        chk("R7 cke low in self-refresh", 32'(cke), 0);
        chk("R9 no exit pulse", 32'(sr_exit), 0);
        req_pending = 1; #1;
        chk("R8 no exit before edge", 32'(sr_exit), 0);
        step();
        chk("R8 exit pulse on request", 32'(sr_exit), 1);
        chk("R8 cke raised", 32'(cke), 32'(M));
        chk("R9 exclusive", 32'(sr_enter), 0);
        step();
        chk("R8 exit one cycle", 32'(sr_exit), 0);
        chk("R8 active again", 32'(cke), 32'(M));

        // C6 entry, exit by return to C0
        pwr_state = 2'd2; req_pending = 0; #1;
        chk("R5 C6 enter pulse", 32'(sr_enter), 1);
        step();
        chk("R7 C6 cke low", 32'(cke), 0);
        pwr_state = 2'd0;
        step();
        chk("R8 exit on C0", 32'(sr_exit), 1);
        step();
        chk("R8 cke after C0 exit", 32'(cke), 32'(M));

        // R6: suspend-to-RAM with flush handshake
        pwr_state = 2'd3; #1;
        chk("R6 no pulse before flush", 32'(sr_enter), 0);
        step();
        chk("R6 flush requested", 32'(flush_req), 1);
        chk("R6 cke high in flush", 32'(cke), 32'(M));
        repeat (3) step();
        chk("R6 waits for flush", 32'(flush_req), 1);
        chk("R6 no early entry", 32'(sr_enter), 0);
        flush_done = 1; #1;
        chk("R6 enter on flush done", 32'(sr_enter), 1);
        step();
        flush_done = 0;
        chk("R6 cke low in suspend", 32'(cke), 0);
        chk("R6 flush_req dropped", 32'(flush_req), 0);
        req_pending = 1;
        repeat (3) step();
        chk("R8 request ignored in suspend", 32'(sr_exit), 0);
        chk("R7 cke low in suspend", 32'(cke), 0);
        req_pending = 0; pwr_state = 2'd0;
        step();
        chk("R8 exit from suspend", 32'(sr_exit), 1);
        chk("R8 cke after suspend", 32'(cke), 32'(M));
        step();

        // R6 abort
        pwr_state = 2'd3;
        step();
        chk("R6 abort flush_req", 32'(flush_req), 1);
        pwr_state = 2'd0; #1;
        chk("R6 abort no pulse", 32'(sr_enter), 0);
        step();
        chk("R6 abort back to active", 32'(flush_req), 0);
        chk("R6 abort cke", 32'(cke), 32'(M));

        // R1: reset from self-refresh
        pwr_state = 2'd1;
        step();
        rst = 1'b1; pwr_state = 2'd0;
        step();
        rst = 1'b0;
        step();
        chk("R1 reset from self-refresh cke", 32'(cke), 0);
        chk("R1 reset restores drive", 32'(cke_oe), 4'hF);
        chk("R1 no exit pulse", 32'(sr_exit), 0);
        summary();
    end
endmodule